// File: doc/BRIEF.md
# Serial Key Unlock Gate for a Memory Bus

This block sits between a host's asynchronous memory bus and a memory array. It turns the raw chip-enable, write-enable and output-enable pins into single-clock bus events. Each event is then steered either to the memory or to a concealed 64-bit register. No address is decoded for the concealed register. Instead, the host must first issue a read to any address, which arms the gate. It must then perform 64 back-to-back writes whose data bit 0 spells out a secret key, least significant key bit first.

Once every key bit has matched, the next 64 bus cycles, reads or writes, stop reaching the memory. Each of them moves one bit into or out of the concealed register, starting at bit 0. After the 64th such cycle the gate closes again. A synchronized power-fail flag freezes the gate: while it is set, no bus cycle reaches either target. The output-drive enable for the data bus is also generated here. It is dropped as soon as write-enable falls.

Top module: `serial_key_gate`

## Requirements
- R1: A read cycle (ce_n low, we_n high) yields exactly one `mem_rd_en` pulse, one clock wide, on the third rising clock edge after the pins settle, provided the gate is not in its transfer phase.
- R2: A write cycle (ce_n and we_n both low) is recognised when it ends, at the first of the two pins to rise. It yields one `mem_wr_en` pulse three edges later. It uses the address and `din0` held during the cycle.
- R3: Any read outside the transfer phase arms the gate with the key pointer at bit 0, including a read in the middle of a partly entered key.
- R4: While armed, a write advances the key pointer only when two conditions hold: addr[20:19] is 00 (address below 0x80000), and `din0` equals KEY[pointer]. Key bit 0 is compared first.
- R5: While armed, a write with a wrong bit or an address at or above 0x80000 disarms the gate. Further writes have no effect until the next read.
- R6: Before the 64th key bit matches, every cycle, including each key write, reaches the memory.
- R7: After the full key matches, the next 64 cycles pulse `hid_wr_sel` or `hid_rd_sel` instead of the memory enables. Transfer n (n = 0..63) writes `din0` into concealed bit n, or presents concealed bit n on `rd_bit` together with the `hid_rd_sel` pulse. `rd_bit` holds that value until the next concealed read.
- R8: After the 64th transfer cycle the gate is closed: the next cycle goes to memory.
- R9: While the synchronized `pwr_fail` is high, bus cycles produce no pulse of any kind and leave the key and transfer progress unchanged.
- R10: `dq_oe` is high only when ce_n and oe_n are low, we_n is high and `pwr_fail` is low, each seen through the synchronizer (two edges). A falling we_n drops it.
- R11: During reset all outputs are low and the gate is closed with the concealed register cleared.
- R12: When we_n rises while ce_n stays low, the ending write and the starting read are seen in the same clock. The write is applied first and the read second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Raw bus chip enable, active low |
| we_n | input | 1 | Raw bus write enable, active low |
| oe_n | input | 1 | Raw bus output enable, active low |
| pwr_fail | input | 1 | Power-fail lockout, active high |
| addr | input | 21 | Bus address |
| din0 | input | 1 | Bus write data bit 0 |
| mem_rd_en | output | 1 | One-clock memory read strobe |
| mem_wr_en | output | 1 | One-clock memory write strobe |
| hid_rd_sel | output | 1 | One-clock concealed-register read select |
| hid_wr_sel | output | 1 | One-clock concealed-register write select |
| rd_bit | output | 1 | Serial read data from the concealed register |
| dq_oe | output | 1 | Data bus output-drive enable |

## Verification
The end of a write and the start of a read land in the same clock whenever the host releases we_n while keeping ce_n low. The bench provokes this in three states: armed, during the transfer phase, and on the last key bit. In the transfer phase one such pin sequence must consume two slots: the write takes bit n and the read returns bit n+1. While armed, the matched write must be followed at once by a re-arm to bit 0. The behavioural model applies the write before the read in the same step, and the bench compares all six outputs against it on every clock.

// File: rtl/skg_pkg.sv
package skg_pkg;

  typedef enum logic [1:0] {
    GATE_CLOSED = 2'd0,
    GATE_ARMED  = 2'd1,
    GATE_XFER   = 2'd2
  } gate_mode_e;

  typedef struct packed {
    logic rd;      // a read cycle has just begun
    logic wr;      // a write cycle has just ended
    logic wbit;    // data bit 0 held during that write
    logic key_ok;  // address of that write lies in the key window
  } bus_evt_t;

endpackage

// File: rtl/skg_bus_sync.sv
module skg_bus_sync
  import skg_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int SPAN_W = 19,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              pwr_fail,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din0,
  output bus_evt_t          evt,
  output logic              dq_oe
);

  localparam int PW = ADDR_W + 5;
  localparam int TOP = SYNC_N - 1;
  localparam logic [PW-1:0] IDLE_V = {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, {ADDR_W{1'b0}}};

  logic [PW-1:0] raw;
  logic [PW-1:0] stg [SYNC_N];

  assign raw = {pwr_fail, oe_n, we_n, ce_n, din0, addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_N; i++) stg[i] <= IDLE_V;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < SYNC_N; i++) stg[i] <= stg[i-1];
    end
  end

  logic              s_pf, s_oe_n, s_we_n, s_ce_n, s_d;
  logic [ADDR_W-1:0] s_addr;
  assign {s_pf, s_oe_n, s_we_n, s_ce_n, s_d, s_addr} = stg[TOP];

  logic rd_act, wr_act, addr_ok;
  assign rd_act  = ~s_ce_n & s_we_n;
  assign wr_act  = ~s_ce_n & ~s_we_n;
  assign addr_ok = ~|s_addr[ADDR_W-1:SPAN_W];

  // previous-cycle view of the synchronized bus
  logic p_rd, p_wr, p_d, p_ok;
  logic n_rd, n_wr, n_d, n_ok;

  always_comb begin
    n_rd = rd_act;
    n_wr = wr_act;
    n_d  = s_d;
    n_ok = addr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rd <= 1'b0;
      p_wr <= 1'b0;
      p_d  <= 1'b0;
      p_ok <= 1'b0;
    end else begin
      p_rd <= n_rd;
      p_wr <= n_wr;
      p_d  <= n_d;
      p_ok <= n_ok;
    end
  end

  assign evt.rd     = rd_act & ~p_rd & ~s_pf;
  assign evt.wr     = p_wr & ~wr_act & ~s_pf;
  assign evt.wbit   = p_d;
  assign evt.key_ok = p_ok;
  assign dq_oe      = ~s_ce_n & ~s_oe_n & s_we_n & ~s_pf;

  // R1
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rd |=> !evt.rd);

  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.wr |=> !evt.wr);

endmodule

// File: rtl/skg_unlock_fsm.sv
module skg_unlock_fsm
  import skg_pkg::*;
#(
  parameter int              KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY  = 64'hA5C3_1E0F_7B29_D468
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bus_evt_t                 evt,
  output logic                     hid_wr_stb,
  output logic [$clog2(KEY_W)-1:0] hid_wr_idx,
  output logic                     hid_rd_stb,
  output logic [$clog2(KEY_W)-1:0] hid_rd_idx,
  output logic                     mem_rd_en,
  output logic                     mem_wr_en,
  output logic                     hid_rd_sel,
  output logic                     hid_wr_sel
);

  localparam int PTR_W = $clog2(KEY_W);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_W - 1);

  gate_mode_e       mode, n_mode;
  logic [PTR_W-1:0] kptr, n_kptr;
  logic [PTR_W-1:0] xptr, n_xptr;
  logic             n_mrd, n_mwr;

  // write is applied before read when both land in one clock
  always_comb begin
    n_mode     = mode;
    n_kptr     = kptr;
    n_xptr     = xptr;
    n_mrd      = 1'b0;
    n_mwr      = 1'b0;
    hid_wr_stb = 1'b0;
    hid_rd_stb = 1'b0;
    hid_wr_idx = xptr;
    hid_rd_idx = xptr;

    if (evt.wr) begin
      if (n_mode == GATE_XFER) begin
        hid_wr_stb = 1'b1;
        hid_wr_idx = n_xptr;
        if (n_xptr == LAST) begin
          n_mode = GATE_CLOSED;
          n_xptr = '0;
        end else begin
          n_xptr = n_xptr + 1'b1;
        end
      end else begin
        n_mwr = 1'b1;
        if (n_mode == GATE_ARMED) begin
          if (evt.key_ok && (evt.wbit == KEY[n_kptr])) begin
            if (n_kptr == LAST) begin
              n_mode = GATE_XFER;
              n_kptr = '0;
              n_xptr = '0;
            end else begin
              n_kptr = n_kptr + 1'b1;
            end
          end else begin
            n_mode = GATE_CLOSED;
            n_kptr = '0;
          end
        end
      end
    end

    if (evt.rd) begin
      if (n_mode == GATE_XFER) begin
        hid_rd_stb = 1'b1;
        hid_rd_idx = n_xptr;
        if (n_xptr == LAST) begin
          n_mode = GATE_CLOSED;
          n_xptr = '0;
        end else begin
          n_xptr = n_xptr + 1'b1;
        end
      end else begin
        n_mrd  = 1'b1;
        n_mode = GATE_ARMED;
        n_kptr = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= GATE_CLOSED;
      kptr       <= '0;
      xptr       <= '0;
      mem_rd_en  <= 1'b0;
      mem_wr_en  <= 1'b0;
      hid_rd_sel <= 1'b0;
      hid_wr_sel <= 1'b0;
    end else begin
      mode       <= n_mode;
      kptr       <= n_kptr;
      xptr       <= n_xptr;
      mem_rd_en  <= n_mrd;
      mem_wr_en  <= n_mwr;
      hid_rd_sel <= hid_rd_stb;
      hid_wr_sel <= hid_wr_stb;
    end
  end

  // R3
  arm_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.rd && !evt.wr && mode != GATE_XFER) |=> (mode == GATE_ARMED && kptr == '0));

  // R5
  disarm_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == GATE_ARMED && evt.wr && !evt.rd && !evt.key_ok) |=> (mode == GATE_CLOSED));

  // R6
  mem_write_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != GATE_XFER && evt.wr) |=> (mem_wr_en && !hid_wr_sel));

  // R8
  close_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == GATE_XFER && xptr == LAST && (evt.wr || evt.rd)) |=> (mode != GATE_XFER));

  // R9
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.rd && !evt.wr) |=> ($stable(mode) && $stable(kptr) && $stable(xptr)));

endmodule

// File: rtl/skg_hidden_reg.sv
module skg_hidden_reg #(
  parameter int W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [$clog2(W)-1:0] wr_idx,
  input  logic                 wbit,
  input  logic                 rd_stb,
  input  logic [$clog2(W)-1:0] rd_idx,
  output logic                 rd_bit
);

  logic [W-1:0] store;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic hit;
      assign hit = wr_stb && (wr_idx == i[$clog2(W)-1:0]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   store[i] <= 1'b0;
        else if (hit) store[i] <= wbit;
      end
    end
  endgenerate

  logic n_rd_bit;
  always_comb n_rd_bit = rd_stb ? store[rd_idx] : rd_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_bit <= 1'b0;
    else        rd_bit <= n_rd_bit;
  end

  // R7
  stored_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (store[$past(wr_idx)] == $past(wbit)));

endmodule

// File: rtl/serial_key_gate.sv
module serial_key_gate
  import skg_pkg::*;
#(
  parameter int               ADDR_W = 21,
  parameter int               SPAN_W = 19,
  parameter int               SYNC_N = 2,
  parameter int               KEY_W  = 64,
  parameter logic [KEY_W-1:0] KEY    = 64'hA5C3_1E0F_7B29_D468
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              pwr_fail,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din0,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic              hid_rd_sel,
  output logic              hid_wr_sel,
  output logic              rd_bit,
  output logic              dq_oe
);

  localparam int PTR_W = $clog2(KEY_W);

  bus_evt_t         evt;
  logic             hw_stb, hr_stb;
  logic [PTR_W-1:0] hw_idx, hr_idx;

  skg_bus_sync #(
    .ADDR_W (ADDR_W),
    .SPAN_W (SPAN_W),
    .SYNC_N (SYNC_N)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .pwr_fail (pwr_fail),
    .addr     (addr),
    .din0     (din0),
    .evt      (evt),
    .dq_oe    (dq_oe)
  );

  skg_unlock_fsm #(
    .KEY_W (KEY_W),
    .KEY   (KEY)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .hid_wr_stb (hw_stb),
    .hid_wr_idx (hw_idx),
    .hid_rd_stb (hr_stb),
    .hid_rd_idx (hr_idx),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .hid_rd_sel (hid_rd_sel),
    .hid_wr_sel (hid_wr_sel)
  );

  skg_hidden_reg #(
    .W (KEY_W)
  ) u_hreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (hw_stb),
    .wr_idx (hw_idx),
    .wbit   (evt.wbit),
    .rd_stb (hr_stb),
    .rd_idx (hr_idx),
    .rd_bit (rd_bit)
  );

  // R10
  oe_drop_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en || hid_wr_sel) |-> !$past(dq_oe, 2));

endmodule

// File: tb/serial_key_gate_tb.sv
module serial_key_gate_tb;

  localparam logic [63:0] KEY   = 64'hA5C3_1E0F_7B29_D468;
  localparam logic [63:0] PATW  = 64'h0123_4567_89AB_CDEF;
  localparam logic [20:0] KADDR = 21'h00123;

  typedef struct packed {
    logic        ce_n;
    logic        we_n;
    logic        oe_n;
    logic        pf;
    logic        d;
    logic [20:0] a;
  } pins_t;

  localparam pins_t IDLE_P = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, pf: 1'b0, d: 1'b0, a: 21'h0};

  logic clk, rst_n;
  logic ce_n, we_n, oe_n, pwr_fail, din0;
  logic [20:0] addr;
  logic mem_rd_en, mem_wr_en, hid_rd_sel, hid_wr_sel, rd_bit, dq_oe;

  int checks = 0;
  int errors = 0;

  serial_key_gate #(.KEY(KEY)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .pwr_fail(pwr_fail), .addr(addr), .din0(din0),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .hid_rd_sel(hid_rd_sel),
    .hid_wr_sel(hid_wr_sel), .rd_bit(rd_bit), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk_bit(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string tag, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // behavioural reference model
  pins_t       h1, h2, h3;
  int          m_mode, m_k, m_x;
  logic [63:0] mh;
  logic        e_mrd, e_mwr, e_hrd, e_hwr, e_rdb, e_oe;
  int          c_mrd, c_mwr, c_hrd, c_hwr, cap_n;
  logic [63:0] cap;

  always @(negedge clk) begin
    if (!rst_n) begin
      h1 = IDLE_P; h2 = IDLE_P; h3 = IDLE_P;
      m_mode = 0; m_k = 0; m_x = 0; mh = '0;
      e_mrd = 0; e_mwr = 0; e_hrd = 0; e_hwr = 0; e_rdb = 0; e_oe = 0;
    end else begin
      chk_bit(mem_rd_en,  e_mrd, "R1",  "mem_rd_en");
      chk_bit(mem_wr_en,  e_mwr, "R2",  "mem_wr_en");
      chk_bit(hid_rd_sel, e_hrd, "R7",  "hid_rd_sel");
      chk_bit(hid_wr_sel, e_hwr, "R7",  "hid_wr_sel");
      chk_bit(rd_bit,     e_rdb, "R7",  "rd_bit");
      chk_bit(dq_oe,      e_oe,  "R10", "dq_oe");
      if (mem_rd_en)  c_mrd++;
      if (mem_wr_en)  c_mwr++;
      if (hid_wr_sel) c_hwr++;
      if (hid_rd_sel) begin
        c_hrd++;
        if (cap_n < 64) cap[cap_n] = rd_bit;
        cap_n++;
      end
      begin
        logic rc, rp, wc, wp, erd, ewr;
        rc = !h2.ce_n && h2.we_n;
        rp = !h3.ce_n && h3.we_n;
        wc = !h2.ce_n && !h2.we_n;
        wp = !h3.ce_n && !h3.we_n;
        erd = rc && !rp && !h2.pf;
        ewr = wp && !wc && !h2.pf;
        e_mrd = 0; e_mwr = 0; e_hrd = 0; e_hwr = 0;
        // R12: write first, then read
        if (ewr) begin
          if (m_mode == 2) begin
            mh[m_x] = h3.d; e_hwr = 1;
            if (m_x == 63) begin m_mode = 0; m_x = 0; end else m_x++;
          end else begin
            e_mwr = 1;
            if (m_mode == 1) begin
              if (h3.a < 21'h80000 && h3.d == KEY[m_k]) begin
                if (m_k == 63) begin m_mode = 2; m_x = 0; m_k = 0; end else m_k++;
              end else begin
                m_mode = 0; m_k = 0;
              end
            end
          end
        end
        if (erd) begin
          if (m_mode == 2) begin
            e_hrd = 1; e_rdb = mh[m_x];
            if (m_x == 63) begin m_mode = 0; m_x = 0; end else m_x++;
          end else begin
            e_mrd = 1; m_mode = 1; m_k = 0;
          end
        end
        e_oe = !h1.ce_n && !h1.oe_n && h1.we_n && !h1.pf;
        h3 = h2; h2 = h1;
        h1 = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n, pf: pwr_fail, d: din0, a: addr};
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_read(input logic [20:0] a);
    @(posedge clk); #1;
    addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    idle(4);
    ce_n = 1; oe_n = 1;
    idle(4);
  endtask

  task automatic bus_write(input logic [20:0] a, input logic b);
    @(posedge clk); #1;
    addr = a; din0 = b; ce_n = 0; we_n = 0; oe_n = 1;
    idle(4);
    ce_n = 1; we_n = 1;
    idle(4);
  endtask

  task automatic bus_wr_rd(input logic [20:0] a, input logic b);
    @(posedge clk); #1;
    addr = a; din0 = b; ce_n = 0; we_n = 0; oe_n = 1;
    idle(4);
    we_n = 1; oe_n = 0;
    idle(4);
    ce_n = 1; oe_n = 1;
    idle(4);
  endtask

  task automatic send_key(input int from);
    for (int i = from; i < 64; i++) bus_write(KADDR, KEY[i]);
  endtask

  int b_mrd, b_mwr, b_hrd, b_hwr;
  task automatic snap;
    b_mrd = c_mrd; b_mwr = c_mwr; b_hrd = c_hrd; b_hwr = c_hwr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    c_mrd = 0; c_mwr = 0; c_hrd = 0; c_hwr = 0; cap_n = 0; cap = '0;
    rst_n = 0; ce_n = 1; we_n = 1; oe_n = 1; pwr_fail = 0; din0 = 0; addr = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk_bit(mem_rd_en | mem_wr_en, 1'b0, "R11", "mem enables in reset");
    chk_bit(hid_rd_sel | hid_wr_sel, 1'b0, "R11", "hidden selects in reset");
    chk_bit(rd_bit | dq_oe, 1'b0, "R11", "rd_bit/dq_oe in reset");
    rst_n = 1;
    idle(3);

    // R1 R2: plain memory traffic
    snap();
    bus_write(21'h00100, 1'b1);
    bus_read(21'h1F000);
    chk_int(c_mwr - b_mwr, 1, "R2", "memory writes");
    chk_int(c_mrd - b_mrd, 1, "R1", "memory reads");

    // R5: mismatch at bit 5 disarms; a later full key is ignored
    snap();
    bus_read(KADDR);
    for (int i = 0; i < 5; i++) bus_write(KADDR, KEY[i]);
    bus_write(KADDR, ~KEY[5]);
    send_key(0);
    bus_write(KADDR, 1'b0);
    chk_int(c_hwr - b_hwr, 0, "R5", "no transfer after mismatch");
    chk_int(c_mwr - b_mwr, 71, "R5", "writes reached memory");

    // R5: key bit 0 from outside the key window disarms
    snap();
    bus_read(KADDR);
    bus_write(21'h80000, KEY[0]);
    send_key(1);
    bus_read(KADDR);
    chk_int(c_hrd - b_hrd, 0, "R5", "no transfer after out-of-window write");
    chk_int(c_mrd - b_mrd, 2, "R5", "reads reached memory");

    // R3 R4 R6: read mid-key restarts at bit 0, then full key
    snap();
    bus_read(KADDR);
    for (int i = 0; i < 10; i++) bus_write(KADDR, KEY[i]);
    bus_read(KADDR);
    send_key(0);
    chk_int(c_mwr - b_mwr, 74, "R6", "key writes reached memory");
    chk_int(c_hwr - b_hwr, 0, "R6", "no hidden write during key");
    // R7: 64 write transfers
    snap();
    for (int i = 0; i < 64; i++) bus_write(21'h00200, PATW[i]);
    chk_int(c_hwr - b_hwr, 64, "R4", "unlocked after re-armed key");
    chk_int(c_mwr - b_mwr, 0, "R7", "memory blocked during transfer");
    // R8: next cycle back to memory
    snap();
    bus_read(KADDR);
    chk_int(c_mrd - b_mrd, 1, "R8", "read after transfer to memory");
    chk_int(c_hrd - b_hrd, 0, "R8", "no hidden read after transfer");
    // R7: read back LSB first
    send_key(0);
    cap_n = 0; cap = '0;
    for (int i = 0; i < 64; i++) bus_read(21'h00300);
    chk_int(cap_n, 64, "R7", "hidden reads");
    checks++;
    if (cap !== PATW) begin
      errors++;
      $display("FAIL R7 readback got %h expected %h", cap, PATW);
    end
    snap();
    bus_write(21'h00300, 1'b1);
    chk_int(c_mwr - b_mwr, 1, "R8", "write after read transfer");

    // R9: power fail freezes the gate
    bus_read(KADDR);
    for (int i = 0; i < 30; i++) bus_write(KADDR, KEY[i]);
    pwr_fail = 1;
    idle(4);
    snap();
    bus_read(KADDR);
    bus_write(KADDR, ~KEY[30]);
    chk_int(c_mrd + c_mwr - b_mrd - b_mwr, 0, "R9", "memory pulses under power fail");
    chk_bit(dq_oe, 1'b0, "R9", "dq_oe under power fail");
    pwr_fail = 0;
    idle(4);
    send_key(30);
    snap();
    bus_read(KADDR);
    chk_int(c_hrd - b_hrd, 1, "R9", "key progress kept across power fail");

    // R12: combined write-then-read in transfer phase (63 slots left)
    snap();
    for (int i = 0; i < 10; i++) bus_wr_rd(21'h00400, PATW[i+7]);
    chk_int(c_hwr - b_hwr, 10, "R12", "hidden writes in combined cycles");
    chk_int(c_hrd - b_hrd, 10, "R12", "hidden reads in combined cycles");
    for (int i = 0; i < 42; i++) bus_read(21'h00400);
    // last slot is the write of a combined cycle; its read goes to memory
    snap();
    bus_wr_rd(21'h00400, 1'b1);
    chk_int(c_hwr - b_hwr, 1, "R12", "last slot taken by write");
    chk_int(c_mrd - b_mrd, 1, "R12", "following read reaches memory");
    // R12 while armed: matched write then re-arm
    bus_wr_rd(KADDR, KEY[0]);
    send_key(0);
    snap();
    bus_write(21'h00500, 1'b1);
    chk_int(c_hwr - b_hwr, 1, "R12", "unlock after re-armed combined cycle");
    for (int i = 0; i < 63; i++) bus_read(21'h00500);

    // R10: output drive drops when we_n falls
    @(posedge clk); #1;
    addr = 21'h00010; ce_n = 0; oe_n = 0; we_n = 1;
    idle(4);
    chk_bit(dq_oe, 1'b1, "R10", "dq_oe during read");
    we_n = 0;
    idle(4);
    chk_bit(dq_oe, 1'b0, "R10", "dq_oe after we_n falls");
    ce_n = 1; oe_n = 1; we_n = 1;
    idle(6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule